// File: doc/BRIEF.md
# Periodic Interrupt and Pulse Generator

This block turns timekeeping carries into a host interrupt flag and a pull-down enable for an open-drain pin. A two-bit selector picks one of four event strobes: a 1/64-second tick, the seconds carry, the minutes carry or the hours carry. When the picked strobe fires, the flag rises and the pin is pulled low.

Two behaviours are offered. In latched mode the flag and the pin stay asserted until the host completes a read of the register that holds the flag. In pulse mode the pin is held low for a fixed window measured in periods of a 128 Hz timing tick, and the flag returns by itself at the end of the window. A read in pulse mode clears the flag at once, but the pin keeps its full window. A mask input blocks new flags and releases the pin. The host has no way to write the flag.

Top module: `prd_irq_gen`

## Requirements
- R1: After reset, irq_flag_o and pull_low_o are both 0.
- R2: sel_i picks the event: 0 (binary 00) the 1/64 s tick, 1 (01) the seconds carry, 2 (10) the minutes carry, 3 (11) the hours carry. A strobe that is not selected has no effect on either output.
- R3: When the selected strobe is high and mask_i is 0 at a rising clock edge, irq_flag_o and pull_low_o are both 1 after that edge.
- R4: With latch_mode_i = 1, flag and pin stay 1 through any number of cycles and timing ticks until flag_rd_i is high at an edge; after that edge both are 0. If a selected event and flag_rd_i arrive at the same edge, the event wins and both stay 1.
- R5: With latch_mode_i = 0, pin and flag stay 1 until the (PULSE_TICKS+1)-th tick128_i after the event, and are 0 after the edge where that tick is sampled. A tick sampled at the same edge as the event is not counted. With the default PULSE_TICKS = 1 this is the second tick after the event.
- R6: With latch_mode_i = 0, flag_rd_i clears irq_flag_o after that edge while pull_low_o keeps its R5 timing.
- R7: While mask_i is 1, no event sets the flag, and pull_low_o is 0 after every edge at which mask_i was 1. A flag already set is kept.
- R8: In pulse mode a new selected event during an active window restarts the window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 2 | Event select (see R2) |
| latch_mode_i | input | 1 | 1 = latched interrupt, 0 = timed pulse |
| mask_i | input | 1 | 1 = block flag setting and release pin |
| tick64_i | input | 1 | 1/64-second event strobe |
| sec_carry_i | input | 1 | Seconds carry strobe |
| min_carry_i | input | 1 | Minutes carry strobe |
| hour_carry_i | input | 1 | Hours carry strobe |
| tick128_i | input | 1 | 128 Hz timing strobe, one cycle wide |
| flag_rd_i | input | 1 | Read of the flag register completed |
| irq_flag_o | output | 1 | Interrupt flag |
| pull_low_o | output | 1 | 1 = drive pin low, 0 = high impedance |

## Verification
Both outputs are registers, so every effect of a strobe, read or mask input sampled at one rising edge is due right after that edge and no later. The bench drives inputs just after a falling edge, holds them for one cycle, and samples the outputs at the next falling edge, which lies half a cycle after the edge that captured them. Pulse-window checks count timing ticks rather than cycles: the outputs are checked as still asserted after the first counted tick and as released just after the closing tick.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [1:0] {
    EV_TICK64 = 2'b00,
    EV_SEC    = 2'b01,
    EV_MIN    = 2'b10,
    EV_HOUR   = 2'b11
  } ev_sel_e;

  localparam int unsigned NUM_EV = 4;
endpackage

// File: rtl/prd_event_mux.sv
module prd_event_mux
  import prd_pkg::*;
#(
  parameter int unsigned N_EV = NUM_EV,
  localparam int unsigned SW = $clog2(N_EV)
) (
  input  logic [SW-1:0]   sel,
  input  logic [N_EV-1:0] strobes,
  input  logic            mask,
  output logic            evt
);
  logic [N_EV-1:0] hit;

  for (genvar g = 0; g < N_EV; g++) begin : g_hit
    assign hit[g] = strobes[g] && (sel == SW'(g));
  end

  assign evt = (|hit) && !mask;
endmodule

// File: rtl/prd_window_timer.sv
module prd_window_timer #(
  parameter int unsigned PULSE_TICKS = 1,
  localparam int unsigned CW = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  input  logic latch_mode,
  input  logic rd,
  output logic drive_nx,
  output logic expire
);
  logic          drive_q;
  logic [CW-1:0] cnt_q;

  assign expire = !start && !latch_mode && drive_q && tick &&
                  (cnt_q == CW'(PULSE_TICKS));

  always_comb begin
    if (start)           drive_nx = 1'b1;
    else if (latch_mode) drive_nx = rd ? 1'b0 : drive_q;
    else                 drive_nx = expire ? 1'b0 : drive_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      drive_q <= drive_nx;
      if (start)
        cnt_q <= '0;
      else if (drive_q && tick && !expire)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/prd_irq_gen.sv
module prd_irq_gen
  import prd_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel_i,
  input  logic       latch_mode_i,
  input  logic       mask_i,
  input  logic       tick64_i,
  input  logic       sec_carry_i,
  input  logic       min_carry_i,
  input  logic       hour_carry_i,
  input  logic       tick128_i,
  input  logic       flag_rd_i,
  output logic       irq_flag_o,
  output logic       pull_low_o
);
  logic [NUM_EV-1:0] strobes;
  logic evt, drive_nx, expire;

  assign strobes[EV_TICK64] = tick64_i;
  assign strobes[EV_SEC]    = sec_carry_i;
  assign strobes[EV_MIN]    = min_carry_i;
  assign strobes[EV_HOUR]   = hour_carry_i;

  prd_event_mux #(.N_EV(NUM_EV)) u_mux (
    .sel(sel_i), .strobes(strobes), .mask(mask_i), .evt(evt)
  );

  prd_window_timer #(.PULSE_TICKS(PULSE_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .start(evt), .tick(tick128_i),
    .latch_mode(latch_mode_i), .rd(flag_rd_i),
    .drive_nx(drive_nx), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag_o <= 1'b0;
      pull_low_o <= 1'b0;
    end else begin
      if (evt)         irq_flag_o <= 1'b1;
      else if (flag_rd_i) irq_flag_o <= 1'b0;
      else if (expire) irq_flag_o <= 1'b0;
      pull_low_o <= drive_nx && !mask_i;
    end
  end
endmodule

// File: rtl/prd_irq_gen_chk.sv
module prd_irq_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] sel_i,
  input logic       latch_mode_i,
  input logic       mask_i,
  input logic       tick64_i,
  input logic       sec_carry_i,
  input logic       min_carry_i,
  input logic       hour_carry_i,
  input logic       tick128_i,
  input logic       flag_rd_i,
  input logic       irq_flag_o,
  input logic       pull_low_o
);
  logic sel_ev;
  always_comb begin
    case (sel_i)
      2'd0:    sel_ev = tick64_i;
      2'd1:    sel_ev = sec_carry_i;
      2'd2:    sel_ev = min_carry_i;
      default: sel_ev = hour_carry_i;
    endcase
  end

  // R3
  event_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_ev && !mask_i) |=> (irq_flag_o && pull_low_o));

  // R7
  mask_release_chk: assert property (@(posedge clk) disable iff (rst)
    mask_i |=> !pull_low_o);

  // R2
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel_ev && !mask_i) |=> !$rose(irq_flag_o));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_mode_i && irq_flag_o && !flag_rd_i) |=> irq_flag_o);

  // R4
  latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_mode_i && flag_rd_i && !(sel_ev && !mask_i)) |=> (!irq_flag_o && !pull_low_o));

  // R5
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch_mode_i && pull_low_o && !tick128_i && !mask_i) |=> pull_low_o);

  // R6
  pulse_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch_mode_i && flag_rd_i && !(sel_ev && !mask_i)) |=> !irq_flag_o);
endmodule

bind prd_irq_gen prd_irq_gen_chk u_chk (.*);

// File: tb/test_prd_irq_gen.sv
module test_prd_irq_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel_i = 2'd0;
  logic latch_mode_i = 1'b1, mask_i = 1'b0;
  logic tick64_i = 1'b0, sec_carry_i = 1'b0, min_carry_i = 1'b0, hour_carry_i = 1'b0;
  logic tick128_i = 1'b0, flag_rd_i = 1'b0;
  logic irq_flag_o, pull_low_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  prd_irq_gen i_prd_irq_gen (.*);

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire(input int which);
    case (which)
      0: tick64_i = 1'b1;
      1: sec_carry_i = 1'b1;
      2: min_carry_i = 1'b1;
      default: hour_carry_i = 1'b1;
    endcase
    @(negedge clk);
    {tick64_i, sec_carry_i, min_carry_i, hour_carry_i} = '0;
  endtask

  task automatic tick();
    tick128_i = 1'b1; @(negedge clk); tick128_i = 1'b0;
  endtask

  task automatic rd();
    flag_rd_i = 1'b1; @(negedge clk); flag_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "flag after reset", irq_flag_o, 1'b0);
    chk("R1", "pin after reset", pull_low_o, 1'b0);
  endtask

  task automatic t_select();
    latch_mode_i = 1'b1;
    for (int s = 0; s < 4; s++) begin
      sel_i = 2'(s);
      fire((s + 1) % 4);
      chk("R2", $sformatf("unselected strobe sel=%0d", s), irq_flag_o, 1'b0);
      fire(s);
      chk("R3", $sformatf("flag sel=%0d", s), irq_flag_o, 1'b1);
      chk("R3", $sformatf("pin sel=%0d", s), pull_low_o, 1'b1);
      rd();
      chk("R4", "flag after read", irq_flag_o, 1'b0);
      chk("R4", "pin after read", pull_low_o, 1'b0);
    end
  endtask

  task automatic t_latch_hold();
    latch_mode_i = 1'b1; sel_i = 2'd1;
    fire(1);
    for (int i = 0; i < 3; i++) begin tick(); idle(4); end
    chk("R4", "flag held", irq_flag_o, 1'b1);
    chk("R4", "pin held", pull_low_o, 1'b1);
    flag_rd_i = 1'b1; sec_carry_i = 1'b1; @(negedge clk);
    flag_rd_i = 1'b0; sec_carry_i = 1'b0;
    chk("R4", "event beats read flag", irq_flag_o, 1'b1);
    chk("R4", "event beats read pin", pull_low_o, 1'b1);
    rd();
    chk("R4", "cleared", irq_flag_o, 1'b0);
  endtask

  task automatic t_pulse();
    latch_mode_i = 1'b0; sel_i = 2'd2;
    min_carry_i = 1'b1; tick128_i = 1'b1; @(negedge clk);
    min_carry_i = 1'b0; tick128_i = 1'b0;
    chk("R5", "set with coincident tick", pull_low_o, 1'b1);
    idle(3); tick();
    chk("R5", "pin after first tick", pull_low_o, 1'b1);
    chk("R5", "flag after first tick", irq_flag_o, 1'b1);
    idle(5);
    chk("R5", "pin between ticks", pull_low_o, 1'b1);
    tick();
    chk("R5", "pin released", pull_low_o, 1'b0);
    chk("R5", "flag auto-return", irq_flag_o, 1'b0);
  endtask

  task automatic t_pulse_read();
    latch_mode_i = 1'b0; sel_i = 2'd3;
    fire(3); rd();
    chk("R6", "flag cleared by read", irq_flag_o, 1'b0);
    chk("R6", "pin kept after read", pull_low_o, 1'b1);
    tick();
    chk("R6", "pin after first tick", pull_low_o, 1'b1);
    tick();
    chk("R6", "pin released on window", pull_low_o, 1'b0);
  endtask

  task automatic t_retrigger();
    latch_mode_i = 1'b0; sel_i = 2'd0;
    fire(0); tick(); fire(0); tick();
    chk("R8", "restarted window pin", pull_low_o, 1'b1);
    tick();
    chk("R8", "restarted window end", pull_low_o, 1'b0);
  endtask

  task automatic t_mask();
    latch_mode_i = 1'b1; sel_i = 2'd1; mask_i = 1'b1;
    fire(1);
    chk("R7", "masked flag", irq_flag_o, 1'b0);
    chk("R7", "masked pin", pull_low_o, 1'b0);
    mask_i = 1'b0; fire(1);
    chk("R7", "unmasked pin", pull_low_o, 1'b1);
    mask_i = 1'b1; @(negedge clk);
    chk("R7", "pin released by mask", pull_low_o, 1'b0);
    chk("R7", "flag kept under mask", irq_flag_o, 1'b1);
    rd(); mask_i = 1'b0; @(negedge clk);
    chk("R7", "flag cleared", irq_flag_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_select();
    t_latch_hold();
    t_pulse();
    t_pulse_read();
    t_retrigger();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule